// File: doc/BRIEF.md
# Calendar Timekeeping Register Core

This block keeps wall-clock time and date in a set of byte-wide registers reached through a simple single-cycle read/write bus. A built-in prescaler counts an oscillator enable (nominally 32.768 kHz) and advances the calendar once per second. Seconds, minutes and hours roll into weekday, day of month, month and a two-digit year, with month lengths and leap years applied. Every field is held in the number format and hour mode that a control register selects.

Software reads a coherent time by watching the busy flag, which rises a fixed number of oscillator ticks before each advance and falls a fixed number after it. To load a new time, software sets the freeze bit, writes the fields and releases the bit. If it also holds the prescaler in reset while doing so, releasing the prescaler last makes the first advance land exactly half a second later. A sticky flag records each completed advance and clears when it is read.

Top module: `rtc_time_core`

## Requirements
- R1: After reset, seconds, minutes, hours and year read 0x00; weekday, day of month and month read 0x01; register 10 reads 0x20, register 11 reads 0x02, register 12 reads 0x00 and register 13 reads 0x80.
- R2: In BCD mode (register 11 bit 2 clear) each advance adds one second in BCD (0x09 becomes 0x10), and carries ripple through every field: 23:59:59 on day 0x31 of month 0x12 in year 0x99 with weekday 7 becomes 00:00:00 on day 0x01 of month 0x01 in year 0x00 with weekday 1.
- R3: Day of month wraps to 1 after day 30 in months 4, 6, 9 and 11, after day 31 in the other months, and in month 2 after day 29 when the year is a multiple of four and after day 28 otherwise.
- R4: With register 11 bit 2 set, all time registers hold and advance as plain binary (seconds 59 wraps to 0 and carries).
- R5: With register 11 bit 1 clear, hours run 1 to 12 with bit 7 of register 4 as the PM flag: 11 AM (0x11) advances to 12 PM (0x92), 11 PM (0x91) to 12 AM (0x12), and 12 PM (0x92) to 1 PM (0x81); with bit 1 set, hours run 0 to 23.
- R6: Register 10 bit 7 reads 1 from WARN_TICKS oscillator ticks before each advance until UPD_TICKS ticks after it, and 0 otherwise; writes to that bit are ignored.
- R7: While register 11 bit 7 is set no advance takes place, the busy bit stays 0 and the time registers remain writable; clearing the bit lets advances resume.
- R8: Register 12 bit 4 is set when the busy window after an advance ends; a read of register 12 returns the flag and clears the register to 0x00; bus writes to register 12 have no effect.
- R9: While register 10 bits 6:4 equal 3'b111 the prescaler is held, no advance happens and the busy bit is 0; after another value is written, the first advance happens DIV_TICKS/2 ticks later.
- R10: Register 13 always reads 0x80 (clock power valid) and ignores writes.
- R11: Read data appears on the cycle after the read strobe and holds until the next strobe; addresses 1, 3, 5, 14 and 15 read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| osc_tick | input | 1 | One-cycle enable per oscillator tick |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
Read data is due one clock after the strobe, so every bench read drives the strobe on a falling edge and samples on the next falling edge. With the oscillator enable held high and the divider released at a known edge E0, the advance lands at E32 for the bench's 64-tick divider. The busy bit is high after edges 24 through 35 and the flag is set at E36, so the busy-window scenario compares the streamed register 10 value against that edge-exact window. The calendar scenarios wait 40 clocks after release, which is past the single advance and well short of the next one, before they read all fields back.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int ADR_SEC  = 0;
  localparam int ADR_MIN  = 2;
  localparam int ADR_HOUR = 4;
  localparam int ADR_WDAY = 6;
  localparam int ADR_MDAY = 7;
  localparam int ADR_MON  = 8;
  localparam int ADR_YEAR = 9;
  localparam int ADR_CTLA = 10;
  localparam int ADR_CTLB = 11;
  localparam int ADR_FLAG = 12;
  localparam int ADR_STAT = 13;

  localparam int B_FREEZE = 7;
  localparam int B_BINARY = 2;
  localparam int B_H24    = 1;
  localparam int C_DONE   = 4;

  localparam logic [6:0] CTLA_RST = 7'h20;
  localparam logic [7:0] CTLB_RST = 8'h02;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] wday;
    logic [7:0] mday;
    logic [7:0] mon;
    logic [7:0] year;
  } rtc_time_t;

  function automatic logic [6:0] bcd2bin(input logic [7:0] v);
    logic [7:0] t;
    t = (8'(v[7:4]) * 8'd10) + 8'(v[3:0]);
    return 7'(t);
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [6:0] b);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = b / 7'd10;
    ones = b - (tens * 7'd10);
    return (8'(tens) << 4) | 8'(ones);
  endfunction

  function automatic logic [6:0] fld_dec(input logic [7:0] v, input logic bin);
    return bin ? v[6:0] : bcd2bin(v);
  endfunction

  function automatic logic [7:0] fld_enc(input logic [6:0] v, input logic bin);
    return bin ? {1'b0, v} : bin2bcd(v);
  endfunction

  function automatic logic [6:0] month_len(input logic [6:0] mo, input logic [1:0] yr_lo);
    logic [6:0] len;
    case (mo)
      7'd2:                     len = (yr_lo == 2'd0) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:  len = 7'd30;
      default:                  len = 7'd31;
    endcase
    return len;
  endfunction

endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_TICKS  = 32768,
  parameter int WARN_TICKS = 8,
  parameter int UPD_TICKS  = 66
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic div_hold,
  input  logic freeze,
  output logic upd_fire,
  output logic upd_done,
  output logic uip
);

  localparam int CNT_W = $clog2(DIV_TICKS);
  localparam int PST_W = $clog2(UPD_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_TICKS - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(DIV_TICKS / 2);
  localparam logic [CNT_W-1:0] CNT_WARN = CNT_W'(DIV_TICKS - WARN_TICKS);
  localparam logic [PST_W-1:0] PST_LOAD = PST_W'(UPD_TICKS);
  localparam logic [PST_W-1:0] PST_ONE  = PST_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PST_W-1:0] pst_q, pst_d;
  logic             cnt_en, pst_en;
  logic             run;

  assign run      = !div_hold && !freeze;
  assign upd_fire = osc_tick && run && (cnt_q == CNT_LAST);
  assign upd_done = osc_tick && run && (pst_q == PST_ONE);
  assign uip      = run && ((cnt_q >= CNT_WARN) || (pst_q != '0));

  always_comb begin
    cnt_en = div_hold || osc_tick;
    if (div_hold) begin
      cnt_d = CNT_HALF;
    end else if (cnt_q == CNT_LAST) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_comb begin
    pst_en = div_hold || upd_fire || (osc_tick && (pst_q != '0));
    if (div_hold) begin
      pst_d = '0;
    end else if (upd_fire) begin
      pst_d = PST_LOAD;
    end else begin
      pst_d = pst_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_HALF;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pst_q <= '0;
    end else if (pst_en) begin
      pst_q <= pst_d;
    end
  end

endmodule

// File: rtl/rtc_cal_next.sv
module rtc_cal_next
  import rtc_pkg::*;
(
  input  rtc_time_t cur,
  input  logic      bin_mode,
  input  logic      h24_mode,
  output rtc_time_t nxt
);

  logic [6:0] s, m, hr, wd, md, mo, yr;
  logic [6:0] h24, hr12_in;
  logic       pm;
  logic [6:0] s_n, m_n, h_n, wd_n, md_n, mo_n, yr_n;
  logic [6:0] dim, h12_out;
  logic       c_min, c_hour, c_day, c_mon, c_year;
  logic [7:0] hour_enc;

  always_comb begin
    s   = fld_dec(cur.sec,  bin_mode);
    m   = fld_dec(cur.min,  bin_mode);
    hr  = fld_dec({1'b0, cur.hour[6:0]}, bin_mode);
    wd  = fld_dec(cur.wday, bin_mode);
    md  = fld_dec(cur.mday, bin_mode);
    mo  = fld_dec(cur.mon,  bin_mode);
    yr  = fld_dec(cur.year, bin_mode);
    pm  = cur.hour[7];

    hr12_in = (hr == 7'd12) ? 7'd0 : hr;
    if (h24_mode) begin
      h24 = hr;
    end else begin
      h24 = pm ? (hr12_in + 7'd12) : hr12_in;
    end
  end

  always_comb begin
    c_min  = (s >= 7'd59);
    s_n    = c_min ? 7'd0 : s + 7'd1;

    c_hour = c_min && (m >= 7'd59);
    m_n    = c_min ? ((m >= 7'd59) ? 7'd0 : m + 7'd1) : m;

    c_day  = c_hour && (h24 >= 7'd23);
    h_n    = c_hour ? ((h24 >= 7'd23) ? 7'd0 : h24 + 7'd1) : h24;

    wd_n   = c_day ? ((wd >= 7'd7) ? 7'd1 : wd + 7'd1) : wd;

    dim    = month_len(mo, yr[1:0]);
    c_mon  = c_day && (md >= dim);
    md_n   = c_day ? ((md >= dim) ? 7'd1 : md + 7'd1) : md;

    c_year = c_mon && (mo >= 7'd12);
    mo_n   = c_mon ? ((mo >= 7'd12) ? 7'd1 : mo + 7'd1) : mo;

    yr_n   = c_year ? ((yr >= 7'd99) ? 7'd0 : yr + 7'd1) : yr;
  end

  always_comb begin
    if (h_n == 7'd0) begin
      h12_out = 7'd12;
    end else if (h_n > 7'd12) begin
      h12_out = h_n - 7'd12;
    end else begin
      h12_out = h_n;
    end

    if (h24_mode) begin
      hour_enc = fld_enc(h_n, bin_mode);
    end else begin
      hour_enc = fld_enc(h12_out, bin_mode);
      hour_enc[7] = (h_n >= 7'd12);
    end

    nxt.sec  = fld_enc(s_n,  bin_mode);
    nxt.min  = fld_enc(m_n,  bin_mode);
    nxt.hour = hour_enc;
    nxt.wday = fld_enc(wd_n, bin_mode);
    nxt.mday = fld_enc(md_n, bin_mode);
    nxt.mon  = fld_enc(mo_n, bin_mode);
    nxt.year = fld_enc(yr_n, bin_mode);
  end

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
#(
  parameter int DIV_TICKS  = 32768,
  parameter int WARN_TICKS = 8,
  parameter int UPD_TICKS  = 66,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);

  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(ADR_SEC);
  localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(ADR_MIN);
  localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(ADR_HOUR);
  localparam logic [ADDR_W-1:0] A_WDAY = ADDR_W'(ADR_WDAY);
  localparam logic [ADDR_W-1:0] A_MDAY = ADDR_W'(ADR_MDAY);
  localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(ADR_MON);
  localparam logic [ADDR_W-1:0] A_YEAR = ADDR_W'(ADR_YEAR);
  localparam logic [ADDR_W-1:0] A_CTLA = ADDR_W'(ADR_CTLA);
  localparam logic [ADDR_W-1:0] A_CTLB = ADDR_W'(ADR_CTLB);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(ADR_FLAG);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);

  localparam rtc_time_t TIME_RST = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                     wday: 8'h01, mday: 8'h01, mon: 8'h01,
                                     year: 8'h00};

  logic       srst_n;
  rtc_time_t  tm_q, tm_d, tm_nxt;
  logic [6:0] ctla_q, ctla_d;
  logic [7:0] ctlb_q, ctlb_d;
  logic       uf_q, uf_d;
  logic [7:0] rdata_q, rdata_d;
  logic       div_hold, freeze;
  logic       upd_fire, upd_done, uip;

  rtc_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  assign div_hold = (ctla_q[6:4] == 3'b111);
  assign freeze   = ctlb_q[B_FREEZE];

  rtc_prescaler #(
    .DIV_TICKS  (DIV_TICKS),
    .WARN_TICKS (WARN_TICKS),
    .UPD_TICKS  (UPD_TICKS)
  ) u_pre (
    .clk      (clk),
    .rst_n    (srst_n),
    .osc_tick (osc_tick),
    .div_hold (div_hold),
    .freeze   (freeze),
    .upd_fire (upd_fire),
    .upd_done (upd_done),
    .uip      (uip)
  );

  rtc_cal_next u_cal (
    .cur      (tm_q),
    .bin_mode (ctlb_q[B_BINARY]),
    .h24_mode (ctlb_q[B_H24]),
    .nxt      (tm_nxt)
  );

  // Next time: an advance first, a bus write to a field takes priority.
  always_comb begin
    tm_d   = upd_fire ? tm_nxt : tm_q;
    ctla_d = ctla_q;
    ctlb_d = ctlb_q;
    if (bus_wr) begin
      case (bus_addr)
        A_SEC:   tm_d.sec  = bus_wdata;
        A_MIN:   tm_d.min  = bus_wdata;
        A_HOUR:  tm_d.hour = bus_wdata;
        A_WDAY:  tm_d.wday = bus_wdata;
        A_MDAY:  tm_d.mday = bus_wdata;
        A_MON:   tm_d.mon  = bus_wdata;
        A_YEAR:  tm_d.year = bus_wdata;
        A_CTLA:  ctla_d    = bus_wdata[6:0];
        A_CTLB:  ctlb_d    = bus_wdata;
        default: ;
      endcase
    end
  end

  // Completion flag: a new completion wins over a clearing read.
  always_comb begin
    if (upd_done) begin
      uf_d = 1'b1;
    end else if (bus_rd && (bus_addr == A_FLAG)) begin
      uf_d = 1'b0;
    end else begin
      uf_d = uf_q;
    end
  end

  always_comb begin
    case (bus_addr)
      A_SEC:   rdata_d = tm_q.sec;
      A_MIN:   rdata_d = tm_q.min;
      A_HOUR:  rdata_d = tm_q.hour;
      A_WDAY:  rdata_d = tm_q.wday;
      A_MDAY:  rdata_d = tm_q.mday;
      A_MON:   rdata_d = tm_q.mon;
      A_YEAR:  rdata_d = tm_q.year;
      A_CTLA:  rdata_d = {uip, ctla_q};
      A_CTLB:  rdata_d = ctlb_q;
      A_FLAG:  rdata_d = 8'(uf_q) << C_DONE;
      A_STAT:  rdata_d = 8'h80;
      default: rdata_d = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      tm_q   <= TIME_RST;
      ctla_q <= CTLA_RST;
      ctlb_q <= CTLB_RST;
      uf_q   <= 1'b0;
    end else begin
      tm_q   <= tm_d;
      ctla_q <= ctla_d;
      ctlb_q <= ctlb_d;
      uf_q   <= uf_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rdata_q <= 8'h00;
    end else if (bus_rd) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/rtc_time_core_chk.sv
module rtc_time_core_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_fire,
  input logic              upd_done,
  input logic              uip,
  input logic              div_hold,
  input logic              freeze,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        sec_q,
  input logic              uf_q,
  input logic [7:0]        bus_rdata
);

  // R6: the busy bit is up in the cycle an advance is taken
  a_r6_busy_at_fire: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |-> uip);

  // R2: an advance without a competing write always moves the seconds
  a_r2_fire_moves_sec: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && !bus_wr) |=> (sec_q != $past(sec_q)));

  // R7: frozen and not written, the seconds stay put
  a_r7_freeze_holds_sec: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !bus_wr) |=> $stable(sec_q));

  // R8: completion sets the flag
  a_r8_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> uf_q);

  // R8: reading the flag register clears it unless a completion coincides
  a_r8_read_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == ADDR_W'(12)) && !upd_done) |=> !uf_q);

  // R9: a held divider neither advances nor shows busy
  a_r9_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    div_hold |-> (!uip && !upd_fire && !upd_done));

  // R11: unimplemented address reads zero one cycle later
  a_r11_gap_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == ADDR_W'(1))) |=> (bus_rdata == 8'h00));

endmodule

bind rtc_time_core rtc_time_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (srst_n),
  .upd_fire  (upd_fire),
  .upd_done  (upd_done),
  .uip       (uip),
  .div_hold  (div_hold),
  .freeze    (freeze),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .sec_q     (tm_q.sec),
  .uf_q      (uf_q),
  .bus_rdata (bus_rdata)
);

// File: tb/tb_rtc_time_core.sv
`timescale 1ns/1ps
module tb_rtc_time_core;

  localparam int DIV  = 64;
  localparam int WARN = 8;
  localparam int UPD  = 4;

  logic       clk;
  logic       rst_n;
  logic       osc_tick;
  logic       bus_rd;
  logic       bus_wr;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;

  int total = 0;
  int bad   = 0;

  rtc_time_core #(
    .DIV_TICKS  (DIV),
    .WARN_TICKS (WARN),
    .UPD_TICKS  (UPD),
    .ADDR_W     (4)
  ) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_tick  (osc_tick),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // Load a time frozen with the divider held, release freeze then divider;
  // the single advance lands 32 clocks after the last write, sampled at 40.
  task automatic load_and_step(input logic [7:0] bv,
                               input logic [7:0] s, input logic [7:0] m,
                               input logic [7:0] h, input logic [7:0] wd,
                               input logic [7:0] md, input logic [7:0] mo,
                               input logic [7:0] yr);
    wr(4'd11, bv | 8'h80);
    wr(4'd0, s); wr(4'd2, m); wr(4'd4, h);
    wr(4'd6, wd); wr(4'd7, md); wr(4'd8, mo); wr(4'd9, yr);
    wr(4'd10, 8'h70);
    wr(4'd11, bv);
    wr(4'd10, 8'h20);
    repeat (40) @(negedge clk);
  endtask

  task automatic expect_time(input string req,
                             input logic [7:0] s, input logic [7:0] m,
                             input logic [7:0] h, input logic [7:0] wd,
                             input logic [7:0] md, input logic [7:0] mo,
                             input logic [7:0] yr);
    logic [7:0] v;
    rd(4'd0, v); chk(req, "seconds", v, s);
    rd(4'd2, v); chk(req, "minutes", v, m);
    rd(4'd4, v); chk(req, "hours",   v, h);
    rd(4'd6, v); chk(req, "weekday", v, wd);
    rd(4'd7, v); chk(req, "mday",    v, md);
    rd(4'd8, v); chk(req, "month",   v, mo);
    rd(4'd9, v); chk(req, "year",    v, yr);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(4'd10, v); chk("R1", "reg10 after reset", v, 8'h20);
    rd(4'd11, v); chk("R1", "reg11 after reset", v, 8'h02);
    rd(4'd12, v); chk("R1", "reg12 after reset", v, 8'h00);
    rd(4'd13, v); chk("R1", "reg13 after reset", v, 8'h80);
    expect_time("R1", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
  endtask

  task automatic t_bcd;
    load_and_step(8'h02, 8'h09, 8'h10, 8'h08, 8'h02, 8'h15, 8'h05, 8'h20);
    expect_time("R2 digit carry", 8'h10, 8'h10, 8'h08, 8'h02, 8'h15, 8'h05, 8'h20);
    load_and_step(8'h02, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    expect_time("R2 full rollover", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
  endtask

  task automatic t_month;
    load_and_step(8'h02, 8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
    expect_time("R3 leap feb", 8'h00, 8'h00, 8'h00, 8'h04, 8'h29, 8'h02, 8'h24);
    load_and_step(8'h02, 8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
    expect_time("R3 common feb", 8'h00, 8'h00, 8'h00, 8'h04, 8'h01, 8'h03, 8'h23);
    load_and_step(8'h02, 8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h04, 8'h23);
    expect_time("R3 30-day month", 8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h05, 8'h23);
  endtask

  task automatic t_binary;
    load_and_step(8'h06, 8'd59, 8'd59, 8'd23, 8'd3, 8'd30, 8'd6, 8'd45);
    expect_time("R4 binary", 8'd0, 8'd0, 8'd0, 8'd4, 8'd1, 8'd7, 8'd45);
    load_and_step(8'h06, 8'd9, 8'd0, 8'd5, 8'd1, 8'd1, 8'd1, 8'd0);
    expect_time("R4 binary no carry", 8'd10, 8'd0, 8'd5, 8'd1, 8'd1, 8'd1, 8'd0);
  endtask

  task automatic t_12h;
    load_and_step(8'h00, 8'h59, 8'h59, 8'h11, 8'h02, 8'h10, 8'h03, 8'h22);
    expect_time("R5 11am to 12pm", 8'h00, 8'h00, 8'h92, 8'h02, 8'h10, 8'h03, 8'h22);
    load_and_step(8'h00, 8'h59, 8'h59, 8'h91, 8'h02, 8'h10, 8'h03, 8'h22);
    expect_time("R5 11pm to 12am", 8'h00, 8'h00, 8'h12, 8'h03, 8'h11, 8'h03, 8'h22);
    load_and_step(8'h00, 8'h59, 8'h59, 8'h92, 8'h02, 8'h10, 8'h03, 8'h22);
    expect_time("R5 12pm to 1pm", 8'h00, 8'h00, 8'h81, 8'h02, 8'h10, 8'h03, 8'h22);
  endtask

  // Divider hold, half-second restart, busy window and completion flag.
  task automatic t_busy;
    logic [7:0] v;
    logic       exp_b;
    wr(4'd11, 8'h02);
    wr(4'd10, 8'hF0);
    rd(4'd10, v); chk("R6 R9", "busy bit write ignored while held", v, 8'h70);
    wr(4'd0, 8'h15);
    rd(4'd12, v);
    repeat (200) @(negedge clk);
    rd(4'd0, v);  chk("R9", "seconds frozen by held divider", v, 8'h15);
    rd(4'd12, v); chk("R9", "no completion while held", v, 8'h00);
    wr(4'd10, 8'h20);                       // edge E0
    bus_rd = 1'b1; bus_addr = 4'd10;
    for (int k = 1; k <= 40; k++) begin
      @(posedge clk);
      @(negedge clk);
      exp_b = (k >= 25) && (k <= 36);       // busy after edges 24..35
      chk("R6", $sformatf("busy window clock %0d", k), bus_rdata, {exp_b, 7'h20});
    end
    bus_rd = 1'b0;
    rd(4'd0, v);  chk("R9", "one advance half a second after release", v, 8'h16);
    rd(4'd12, v); chk("R8", "completion flag set", v, 8'h10);
    rd(4'd12, v); chk("R8", "flag cleared by read", v, 8'h00);
    wr(4'd12, 8'hFF);
    rd(4'd12, v); chk("R8", "write to flag ignored", v, 8'h00);
  endtask

  task automatic t_freeze;
    logic [7:0] v;
    load_and_step(8'h02, 8'h30, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06);
    wr(4'd11, 8'h82);
    rd(4'd12, v);
    repeat (200) @(negedge clk);
    rd(4'd0, v);  chk("R7", "seconds held while frozen", v, 8'h31);
    rd(4'd10, v); chk("R7", "busy low while frozen", v, 8'h20);
    rd(4'd12, v); chk("R7", "no completion while frozen", v, 8'h00);
    wr(4'd0, 8'h44);
    rd(4'd0, v);  chk("R7", "write accepted while frozen", v, 8'h44);
    wr(4'd10, 8'h70);
    wr(4'd11, 8'h02);
    wr(4'd10, 8'h20);
    repeat (40) @(negedge clk);
    rd(4'd0, v);  chk("R7", "advance resumes after unfreeze", v, 8'h45);
  endtask

  task automatic t_misc;
    logic [7:0] v;
    wr(4'd13, 8'h00);
    rd(4'd13, v); chk("R10", "power valid ignores write", v, 8'h80);
    rd(4'd1, v);  chk("R11", "addr 1 reads zero", v, 8'h00);
    rd(4'd3, v);  chk("R11", "addr 3 reads zero", v, 8'h00);
    rd(4'd5, v);  chk("R11", "addr 5 reads zero", v, 8'h00);
    rd(4'd14, v); chk("R11", "addr 14 reads zero", v, 8'h00);
    rd(4'd15, v); chk("R11", "addr 15 reads zero", v, 8'h00);
    rd(4'd13, v);
    @(negedge clk);
    bus_addr = 4'd1;
    @(negedge clk);
    chk("R11", "read data holds without strobe", bus_rdata, 8'h80);
  endtask

  initial begin
    rst_n = 1'b0; osc_tick = 1'b1;
    bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_bcd();
    t_month();
    t_binary();
    t_12h();
    t_busy();
    t_freeze();
    t_misc();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule